// File: doc/BRIEF.md
# Chained Descriptor Channel Sequencer

This block is one channel of a memory-mastering crypto accelerator. Software writes the address of a descriptor into the channel's fetch port. The channel then reads the 9-word descriptor from system memory one 64-bit word at a time. It takes the execution-unit selection and the mode from the header, and walks the seven length/pointer pairs in index order. A pair with a non-zero length becomes a run of word transfers between memory and the execution-unit port. The direction is read toward the unit for pairs 1, 2, 3, 6 and 7, and written from the unit for pairs 4 and 5. A pair with zero length is passed over with no traffic. After the last pair the channel follows the next-descriptor pointer, or stops when that pointer is zero.

Completion is reported per descriptor or only at the end of the chain, depending on a mode input. It is reported by an interrupt pulse, by writing the header back to the descriptor's first word with bit 0 set, or by both. An error response from memory aborts the chain at once. It sets a sticky error flag, pulses the interrupt and returns the channel to idle.

States: `S_IDLE` (waiting for a fetch write), `S_FETCH` (reading descriptor words 0..8), `S_SCAN` (choosing the next non-empty pair), `S_RD_MEM` / `S_RD_PUSH` (reading a word, then handing it to the unit), `S_WR_PULL` / `S_WR_MEM` (taking a word from the unit, then writing it), `S_DESC_END` (deciding on done and chaining), and `S_WRITEBACK` (header write-back). The transitions are as follows.
- IDLE to FETCH on a fetch write.
- FETCH to SCAN after word 8.
- SCAN to RD_MEM or WR_PULL when a pair is found, and to DESC_END when none is left.
- RD_PUSH or WR_MEM return to SCAN after the last word of a pair, and otherwise go back to RD_MEM or WR_PULL.
- DESC_END goes to WRITEBACK, to FETCH (next descriptor) or to IDLE.
- WRITEBACK goes to FETCH or IDLE.
- Any memory error goes to IDLE.

Top module: `dchan_top`

## Requirements
- R1: A write on `fetch_we` while idle starts processing at `fetch_ptr`, and `busy` is high from the next cycle until the chain ends. A fetch write while busy is ignored.
- R2: Each descriptor is read as 9 single-word memory reads at `ptr + 8*k`, k = 0..8. Word 0 is the header. Words 1..7 hold pair k with the length in bits 63:32 and the pointer in bits 31:0. Word 8 holds the next pointer in bits 31:0.
- R3: While data moves, `eu_unit` shows header bits 11:8, `eu_mode` shows header bits 23:16, and `eu_slot` shows the pair index.
- R4: A non-zero read pair (index 1, 2, 3, 6 or 7) reads ceil(len/8) words from pointer, pointer+8 and so on. It offers each word to the unit in order on `eu_wdata`.
- R5: A non-zero write pair (index 4 or 5) takes ceil(len/8) words from the unit. It writes them to pointer, pointer+8 and so on in order.
- R6: A pair with length zero causes no memory access and no unit transfer.
- R7: The unit side obeys flow control. A word offered with `eu_wvalid` is held until `eu_wready`. A word is taken only when `eu_rvalid` and `eu_rready` are both high.
- R8: After a descriptor, a non-zero next pointer starts a fetch there. A zero next pointer ends the chain and `busy` falls.
- R9: With `cfg_chain_done` = 0, done is signalled after every descriptor. With `cfg_chain_done` = 1, done is signalled only after the descriptor whose next pointer is zero.
- R10: On done with `cfg_wb_en` = 1, the header is written to word 0 of that descriptor with bit 0 set and every other bit unchanged. Headers of descriptors not signalled are left unwritten.
- R11: On done with `cfg_irq_en` = 1, `irq` pulses high for exactly one cycle.
- R12: A memory error response aborts the chain. It sets `err`, pulses `irq` whatever the enables and done mode are, returns to idle and makes no further requests. `err` stays set until the next accepted fetch write clears it.
- R13: After reset, `busy`, `irq`, `err`, `mem_req`, `eu_wvalid` and `eu_rready` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_we | input | 1 | Fetch register write strobe |
| fetch_ptr | input | 32 | Descriptor address written to the fetch register |
| cfg_chain_done | input | 1 | 1: done only at chain end; 0: done per descriptor |
| cfg_irq_en | input | 1 | Enable interrupt on done |
| cfg_wb_en | input | 1 | Enable header write-back on done |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word address of the request |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Error response, valid with `mem_ack` |
| eu_unit | output | 4 | Selected execution unit from the header |
| eu_mode | output | 8 | Mode from the header |
| eu_slot | output | 3 | Index of the pair being transferred |
| eu_wvalid | output | 1 | Word offered to the unit |
| eu_wdata | output | 64 | Word to the unit |
| eu_wready | input | 1 | Unit accepts the offered word |
| eu_rvalid | input | 1 | Unit offers an output word |
| eu_rdata | input | 64 | Output word from the unit |
| eu_rready | output | 1 | Channel takes the unit's word |
| busy | output | 1 | Channel is processing |
| irq | output | 1 | One-cycle done or error interrupt |
| err | output | 1 | Sticky memory-error flag |

## Verification
The assertions assume several things about the environment. Memory holds `mem_ack` for one cycle per request, and raises it only while `mem_req` is high. The unit and the software follow the handshakes. All pointers are multiples of 8. The bench's memory model answers only a pending request, after a random delay of 0 to 2 cycles, and drops the acknowledge on the following cycle. The unit stub toggles `eu_wready` and `eu_rvalid` at random without ever taking back an offered word. Every descriptor and data region the bench builds sits at an 8-byte-aligned address with lengths of 0 to 40 bytes.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
    localparam int PAIRS      = 7;
    localparam int DESC_WORDS = PAIRS + 2;
    localparam int IDX_W      = 4;
    localparam int UNIT_LSB   = 8;
    localparam int UNIT_W     = 4;
    localparam int MODE_LSB   = 16;
    localparam int MODE_W     = 8;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_SCAN, S_RD_MEM, S_RD_PUSH,
        S_WR_PULL, S_WR_MEM, S_DESC_END, S_WRITEBACK
    } state_t;

    function automatic logic slot_writes(input logic [IDX_W-1:0] idx);
        return (idx == 4'd4) || (idx == 4'd5);
    endfunction
endpackage

// File: rtl/dchan_desc_store.sv
module dchan_desc_store
    import dchan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [DW-1:0]              wr_data,
    output logic [DW-1:0]              hdr_o,
    output logic [AW-1:0]              next_o,
    output logic [PAIRS-1:0][AW-1:0]   lens_o,
    output logic [PAIRS-1:0][AW-1:0]   ptrs_o
);
    logic [DW-1:0] words [DESC_WORDS];

    for (genvar k = 0; k < DESC_WORDS; k++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[k] <= '0;
            else if (wr_en && (wr_idx == IDX_W'(k)))
                words[k] <= wr_data;
        end
    end

    for (genvar p = 1; p <= PAIRS; p++) begin : g_pair
        assign lens_o[p-1] = words[p][2*AW-1:AW];
        assign ptrs_o[p-1] = words[p][AW-1:0];
    end

    assign hdr_o  = words[0];
    assign next_o = words[DESC_WORDS-1][AW-1:0];
endmodule

// File: rtl/dchan_pair_scan.sv
module dchan_pair_scan
    import dchan_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [PAIRS-1:0][AW-1:0] lens_i,
    input  logic [IDX_W-1:0]         start_i,
    output logic                     found_o,
    output logic [IDX_W-1:0]         idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = PAIRS; i >= 1; i--) begin
            if ((IDX_W'(i) >= start_i) && (lens_i[i-1] != '0)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/dchan_top.sv
module dchan_top
    import dchan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_we,
    input  logic [AW-1:0]     fetch_ptr,
    input  logic              cfg_chain_done,
    input  logic              cfg_irq_en,
    input  logic              cfg_wb_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_err,
    output logic [UNIT_W-1:0] eu_unit,
    output logic [MODE_W-1:0] eu_mode,
    output logic [2:0]        eu_slot,
    output logic              eu_wvalid,
    output logic [DW-1:0]     eu_wdata,
    input  logic              eu_wready,
    input  logic              eu_rvalid,
    input  logic [DW-1:0]     eu_rdata,
    output logic              eu_rready,
    output logic              busy,
    output logic              irq,
    output logic              err
);
    localparam int BYTE_SH = 3;
    localparam logic [AW-1:0] STEP = AW'(1 << BYTE_SH);

    state_t state_q, state_d;
    logic [IDX_W-1:0] widx_q, pidx_q, sc_idx;
    logic [AW-1:0] desc_q, cur_q, remain_q, next_ptr;
    logic [DW-1:0] buf_q, hdr;
    logic irq_q, err_q, sc_found;
    logic [PAIRS-1:0][AW-1:0] lens, ptrs;
    logic [2:0] sc_sel;
    logic [AW:0] len_round;
    logic last_desc, signal_done, ack_ok, ack_bad, word_done;

    dchan_desc_store #(.AW(AW), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(state_q == S_FETCH && ack_ok), .wr_idx(widx_q), .wr_data(mem_rdata),
        .hdr_o(hdr), .next_o(next_ptr), .lens_o(lens), .ptrs_o(ptrs)
    );

    dchan_pair_scan #(.AW(AW)) u_scan (
        .lens_i(lens), .start_i(pidx_q), .found_o(sc_found), .idx_o(sc_idx)
    );

    assign sc_sel      = 3'(sc_idx - 4'd1);
    assign len_round   = {1'b0, lens[sc_sel]} + (AW+1)'(STEP - 1);
    assign last_desc   = (next_ptr == '0);
    assign signal_done = !cfg_chain_done || last_desc;
    assign ack_ok      = mem_req && mem_ack && !mem_err;
    assign ack_bad     = mem_req && mem_ack && mem_err;
    assign word_done   = (state_q == S_RD_PUSH && eu_wready) || (state_q == S_WR_MEM && ack_ok);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (fetch_we) state_d = S_FETCH;
            S_FETCH:     if (ack_bad) state_d = S_IDLE;
                         else if (ack_ok && widx_q == IDX_W'(DESC_WORDS-1)) state_d = S_SCAN;
            S_SCAN:      if (!sc_found) state_d = S_DESC_END;
                         else state_d = slot_writes(sc_idx) ? S_WR_PULL : S_RD_MEM;
            S_RD_MEM:    if (ack_bad) state_d = S_IDLE;
                         else if (ack_ok) state_d = S_RD_PUSH;
            S_RD_PUSH:   if (eu_wready) state_d = (remain_q == 1) ? S_SCAN : S_RD_MEM;
            S_WR_PULL:   if (eu_rvalid) state_d = S_WR_MEM;
            S_WR_MEM:    if (ack_bad) state_d = S_IDLE;
                         else if (ack_ok) state_d = (remain_q == 1) ? S_SCAN : S_WR_PULL;
            S_DESC_END:  if (signal_done && cfg_wb_en) state_d = S_WRITEBACK;
                         else state_d = last_desc ? S_IDLE : S_FETCH;
            S_WRITEBACK: if (ack_bad) state_d = S_IDLE;
                         else if (ack_ok) state_d = last_desc ? S_IDLE : S_FETCH;
            default:     state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == S_FETCH) || (state_q == S_RD_MEM) ||
                    (state_q == S_WR_MEM) || (state_q == S_WRITEBACK);
        mem_we    = (state_q == S_WR_MEM) || (state_q == S_WRITEBACK);
        mem_addr  = cur_q;
        mem_wdata = buf_q;
        if (state_q == S_FETCH)     mem_addr = desc_q + AW'({widx_q, 3'b000});
        if (state_q == S_WRITEBACK) begin
            mem_addr  = desc_q;
            mem_wdata = hdr | DW'(1);
        end
        eu_wvalid = (state_q == S_RD_PUSH);
        eu_rready = (state_q == S_WR_PULL);
        eu_wdata  = buf_q;
        eu_slot   = pidx_q[2:0];
        eu_unit   = hdr[UNIT_LSB +: UNIT_W];
        eu_mode   = hdr[MODE_LSB +: MODE_W];
        busy      = (state_q != S_IDLE);
        irq       = irq_q;
        err       = err_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx_q <= '0; pidx_q <= '0; desc_q <= '0; cur_q <= '0;
            remain_q <= '0; buf_q <= '0; irq_q <= 1'b0; err_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (state_q == S_IDLE && fetch_we) begin
                desc_q <= fetch_ptr;
                widx_q <= '0;
                err_q  <= 1'b0;
            end
            if (state_q == S_FETCH && ack_ok) begin
                widx_q <= widx_q + 1'b1;
                pidx_q <= 4'd1;
            end
            if (state_q == S_SCAN && sc_found) begin
                pidx_q   <= sc_idx;
                cur_q    <= ptrs[sc_sel];
                remain_q <= len_round[AW:BYTE_SH] == '0 ? AW'(1) : AW'(len_round[AW:BYTE_SH]);
            end
            if (state_q == S_RD_MEM && ack_ok) buf_q <= mem_rdata;
            if (state_q == S_WR_PULL && eu_rvalid) buf_q <= eu_rdata;
            if (word_done) begin
                cur_q    <= cur_q + STEP;
                remain_q <= remain_q - 1'b1;
                if (remain_q == 1) pidx_q <= pidx_q + 1'b1;
            end
            if ((state_q == S_DESC_END && !(signal_done && cfg_wb_en)) ||
                (state_q == S_WRITEBACK && ack_ok)) begin
                irq_q <= signal_done && cfg_irq_en;
                if (!last_desc) begin
                    desc_q <= next_ptr;
                    widx_q <= '0;
                end
            end
            if (ack_bad) begin
                err_q <= 1'b1;
                irq_q <= 1'b1;
            end
        end
    end

    a_r1_fetch_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fetch_we) |=> busy);
    a_r1_busy_fetch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fetch_we && state_q != S_DESC_END && state_q != S_WRITEBACK) |=> $stable(desc_q));
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    a_r7_push_held: assert property (@(posedge clk) disable iff (!rst_n)
        (eu_wvalid && !eu_wready) |=> (eu_wvalid && $stable(eu_wdata)));
    a_r7_pull_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (eu_rready && !eu_rvalid) |=> eu_rready);
    a_r11_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r12_err_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (err && irq && !busy));
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(!busy && fetch_we)) |=> err);
endmodule

// File: tb/dchan_top_tb_top.sv
module dchan_top_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic fetch_we = 0, cfg_chain_done = 0, cfg_irq_en = 0, cfg_wb_en = 0;
    logic [31:0] fetch_ptr = '0;
    logic mem_req, mem_we, mem_ack = 0, mem_err = 0;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata = '0;
    logic [3:0] eu_unit;
    logic [7:0] eu_mode;
    logic [2:0] eu_slot;
    logic eu_wvalid, eu_wready = 0, eu_rvalid = 0, eu_rready, busy, irq, err;
    logic [63:0] eu_wdata, eu_rdata = '0;

    always #2 clk = ~clk;

    dchan_top dut_i (.*);

    int checks = 0, fails = 0;
    logic [63:0] mem [int unsigned];
    int unsigned ops = 0, irq_cnt = 0, eu_out_cnt = 0;
    int unsigned err_addr = 0;
    bit err_armed = 0;
    int dly = 0;
    logic [78:0] got_q [$];
    int unsigned L [4][8];
    logic [31:0] hdrv [4];

    function automatic logic [63:0] rd(input int unsigned a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction
    function automatic logic [63:0] pat(input int unsigned n);
        return {32'hE0E0_0000 | n, ~n};
    endfunction
    function automatic int unsigned nwords(input int unsigned len);
        return (len + 7) / 8;
    endfunction
    function automatic bit is_wr(input int p);
        return p == 4 || p == 5;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 0; mem_err = 0;
        end else if (mem_req) begin
            if (dly > 0) dly--;
            else begin
                ops++;
                if (err_armed && mem_addr == err_addr) begin
                    mem_err = 1; err_armed = 0;
                end else if (mem_we) mem[mem_addr] = mem_wdata;
                else mem_rdata = rd(mem_addr);
                mem_ack = 1;
                dly = $urandom % 3;
            end
        end
    end

    // unit stub
    always @(negedge clk) begin
        eu_wready = ($urandom % 4) != 0;
        eu_rvalid = ($urandom % 3) != 0;
        eu_rdata  = pat(eu_out_cnt);
    end
    always @(posedge clk) begin
        if (eu_wvalid && eu_wready) got_q.push_back({eu_unit, eu_mode, eu_slot, eu_wdata});
        if (eu_rvalid && eu_rready) eu_out_cnt++;
        if (irq) irq_cnt++;
    end

    task automatic build(input int nd);
        for (int d = 0; d < nd; d++) begin
            int unsigned base = 32'h1000 + d * 32'h100;
            mem[base] = {32'h0, hdrv[d] & 32'hFFFF_FFFE};
            for (int p = 1; p <= 7; p++) begin
                int unsigned ptr = 32'h10000 + d * 32'h1000 + p * 32'h200;
                mem[base + 8*p] = {L[d][p], ptr};
                for (int w = 0; w < nwords(L[d][p]); w++)
                    mem[ptr + 8*w] = is_wr(p) ? 64'hDEAD_BEEF_DEAD_BEEF : {$urandom, $urandom};
            end
            mem[base + 64] = (d == nd - 1) ? 64'h0 : {32'hFFFF_FFFF, base + 32'h100};
        end
    endtask

    task automatic wait_idle(input string req);
        int t = 0;
        while (busy && t < 20000) begin @(negedge clk); t++; end
        check(!busy, req, "chain did not end", {63'h0, busy}, 64'h0);
    endtask

    task automatic run_chain(input int nd, input bit cm, input bit ie, input bit we, input bit junk);
        logic [78:0] exp_q [$];
        int unsigned n0, ops0, irq0, exp_ops, exp_irq, n;
        bit ok;
        build(nd);
        // a garbage descriptor that must never be processed
        mem[32'h9000] = 64'h0000_00FF;
        for (int p = 1; p <= 8; p++) mem[32'h9000 + 8*p] = {32'h100, 32'h20000};
        exp_ops = 0; exp_irq = 0;
        for (int d = 0; d < nd; d++) begin
            bit sig = !cm || (d == nd - 1);
            exp_ops += 9;
            for (int p = 1; p <= 7; p++) begin
                int unsigned ptr = 32'h10000 + d * 32'h1000 + p * 32'h200;
                exp_ops += nwords(L[d][p]);
                if (!is_wr(p))
                    for (int w = 0; w < nwords(L[d][p]); w++)
                        exp_q.push_back({hdrv[d][11:8], hdrv[d][23:16], 3'(p), rd(ptr + 8*w)});
            end
            if (sig && we) exp_ops++;
            if (sig && ie) exp_irq++;
        end
        got_q.delete();
        n0 = eu_out_cnt; ops0 = ops; irq0 = irq_cnt;
        @(negedge clk);
        cfg_chain_done = cm; cfg_irq_en = ie; cfg_wb_en = we;
        fetch_we = 1; fetch_ptr = 32'h1000;
        @(negedge clk);
        fetch_we = 0;
        check(busy == 1, "R1", "busy after fetch", {63'h0, busy}, 64'h1);
        if (junk) begin
            repeat (5) @(negedge clk);
            fetch_we = 1; fetch_ptr = 32'h9000;
            @(negedge clk);
            fetch_we = 0;
        end
        wait_idle("R8");
        repeat (3) @(negedge clk);
        check(err == 0, "R8", "no error on clean chain", {63'h0, err}, 64'h0);
        check(ops - ops0 == exp_ops, "R2/R6", "memory access count",
              64'(ops - ops0), 64'(exp_ops));
        ok = (got_q.size() == exp_q.size());
        check(ok, "R4/R7", "unit word count", 64'(got_q.size()), 64'(exp_q.size()));
        if (ok) for (int i = 0; i < exp_q.size(); i++)
            if (got_q[i] != exp_q[i]) begin
                check(0, "R3/R4", "unit word/unit/mode/slot", got_q[i][63:0], exp_q[i][63:0]);
                break;
            end
        n = n0; ok = 1;
        for (int d = 0; d < nd && ok; d++)
            for (int p = 4; p <= 5 && ok; p++)
                for (int w = 0; w < nwords(L[d][p]); w++) begin
                    int unsigned a = 32'h10000 + d * 32'h1000 + p * 32'h200 + 8*w;
                    if (rd(a) != pat(n)) begin
                        check(0, "R5", "written unit output", rd(a), pat(n));
                        ok = 0; break;
                    end
                    n++;
                end
        check(ok && eu_out_cnt == n, "R5", "unit words taken", 64'(eu_out_cnt - n0), 64'(n - n0));
        check(irq_cnt - irq0 == exp_irq, "R9/R11", "interrupt pulses",
              64'(irq_cnt - irq0), 64'(exp_irq));
        for (int d = 0; d < nd; d++) begin
            bit sig = !cm || (d == nd - 1);
            logic [63:0] eh = {32'h0, hdrv[d] & 32'hFFFF_FFFE} | {63'h0, sig && we};
            check(rd(32'h1000 + d * 32'h100) == eh, "R10", "header write-back",
                  rd(32'h1000 + d * 32'h100), eh);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(negedge clk);
        check(!busy && !irq && !err && !mem_req && !eu_wvalid && !eu_rready, "R13",
              "reset outputs", {58'h0, busy, irq, err, mem_req, eu_wvalid, eu_rready}, 64'h0);
        rst_n = 1;
        @(negedge clk);

        // directed: all pairs empty
        hdrv[0] = 32'h00AB_0300;
        for (int p = 1; p <= 7; p++) L[0][p] = 0;
        run_chain(1, 0, 1, 1, 0);                      // R6 only fetch + write-back
        // directed: odd lengths, pairs 6 and 7 used
        hdrv[0] = 32'h0055_0700;
        L[0] = '{0, 1, 9, 16, 3, 17, 8, 24};
        run_chain(1, 0, 1, 0, 0);
        // directed: chain of 3, done at chain end, fetch write while busy (R1)
        for (int d = 0; d < 3; d++) begin
            hdrv[d] = 32'h0010_0100 * (d + 1);
            L[d] = '{0, 8, 0, 12, 8, 0, 0, 0};
        end
        run_chain(3, 1, 1, 1, 1);
        // same chain, per-descriptor done, write-back only
        run_chain(3, 0, 0, 1, 0);

        // random
        for (int r = 0; r < 16; r++) begin
            int nd = 1 + $urandom % 3;
            for (int d = 0; d < nd; d++) begin
                hdrv[d] = $urandom;
                for (int p = 1; p <= 7; p++)
                    L[d][p] = ($urandom % 3 == 0 || p >= 6 && $urandom % 2 == 0) ? 0 : $urandom % 41;
            end
            run_chain(nd, $urandom % 2, $urandom % 2, $urandom % 2, r % 4 == 0);
        end

        // R12: error during a data read, interrupt with enables off
        begin
            int unsigned ops0, irq0;
            hdrv[0] = 32'h0000_0200;
            L[0] = '{0, 0, 0, 16, 0, 0, 0, 0};
            L[1] = '{0, 0, 0, 8, 0, 0, 0, 0};
            build(2);
            err_addr = 32'h10000 + 3 * 32'h200 + 8; err_armed = 1;
            irq0 = irq_cnt;
            @(negedge clk);
            cfg_chain_done = 0; cfg_irq_en = 0; cfg_wb_en = 1;
            fetch_we = 1; fetch_ptr = 32'h1000;
            @(negedge clk);
            fetch_we = 0;
            wait_idle("R12");
            ops0 = ops;
            repeat (20) @(negedge clk);
            check(err == 1, "R12", "error flag set", {63'h0, err}, 64'h1);
            check(irq_cnt - irq0 == 1, "R12", "error interrupt", 64'(irq_cnt - irq0), 64'h1);
            check(ops == ops0 && !busy, "R12", "no traffic after abort", 64'(ops - ops0), 64'h0);
            check(rd(32'h1000) == 64'h200, "R12", "no write-back after abort", rd(32'h1000), 64'h200);
            @(negedge clk);
            fetch_we = 1; fetch_ptr = 32'h1000;
            @(negedge clk);
            fetch_we = 0;
            check(err == 0, "R12", "error cleared by fetch", {63'h0, err}, 64'h0);
            wait_idle("R12");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule